// File: doc/BRIEF.md
# Console Serial Register Interface

This block is the register face of a console serial port. A processor reaches it over a simple register bus that has an address, a read strobe, a write strobe, 32-bit write data and 32-bit registered read data. Incoming characters arrive as a byte stream with a valid/ready handshake. Outgoing characters leave as a one-cycle byte pulse, and that sink is assumed to accept every byte. Bit timing, framing and buffering are handled outside this block.

The receive side and the transmit side each have a control/status register. In each one, bit 6 is the interrupt enable and bit 7 is a live status flag. When an enabled condition is present, the block raises an interrupt request and selects one of two fixed vector codes. It also drives a pending flag that is meant to sit in bit 28 of a shared system status word. Software acknowledges the interrupt by writing either status register.

Top module: `con_serial_regs`

## Requirements
- R1: The registers sit at fixed offsets. Receive status is at 0x80, receive data at 0x84, transmit status at 0x88 and transmit data at 0x8C. For a read strobed in cycle N, `bus_rdata` shows the value in cycle N+1 and holds it until the next read.
- R2: A status register read returns the stored bits [6:0] of the last write to that register, with bits [31:8] reading as zero. Bit 6 is the interrupt enable. In the receive status register, bit 7 reads 1 exactly when `rx_valid` is high in the read cycle.
- R3: Bit 7 of the transmit status register always reads 1, meaning the transmitter is ready.
- R4: A read of receive data returns the waiting byte in bits [7:0] and consumes it: `rx_ready` is high in that same cycle. If no byte is waiting, the read returns 0 and `rx_ready` stays low.
- R5: If the receive enable is set and a byte is waiting, then in the next cycle `irq_req` and `sys_pending` are 1 and `irq_vector` is 0xF8.
- R6: If the transmit enable is set, then in the next cycle `irq_req` and `sys_pending` are 1 and `irq_vector` is 0xFC.
- R7: A write to either status register stores bits [6:0] of the write data. In the next cycle it clears `irq_req` and `sys_pending`, and this clear wins over a set in the same cycle. When no condition is present and no acknowledge occurs, the request holds its value.
- R8: If the receive and transmit conditions are true in the same cycle, the vector presented is 0xFC.
- R9: A write to transmit data makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits [7:0] of the written value.
- R10: A read at offset 0x100 returns 128. Any other unmapped offset reads as 0, and a write there changes neither register nor any output.
- R11: After reset, both enables are clear, `irq_req`, `sys_pending`, `tx_valid`, `irq_vector` and `bus_rdata` are 0, and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | A received byte is waiting |
| rx_data | input | 8 | The waiting received byte |
| rx_ready | output | 1 | Consume the waiting byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq_req | output | 1 | Interrupt request line |
| irq_vector | output | 8 | Selected interrupt vector code |
| sys_pending | output | 1 | Pending flag for bit 28 of the shared status word |

## Verification
The interrupt logic is driven with four patterns: receive enable alone with and without a waiting byte, transmit enable alone, both enables with a byte waiting, and acknowledges that land while a condition is still live. Together these separate the vector priority, the clear-wins-over-set rule, and the way the request rearms one cycle after an acknowledge. Receive data is read both with a byte waiting and with none, which shows that consumption and the zero return are handled correctly. Writes to unmapped offsets are followed by status reads, to show that nothing in the block changed.

// File: rtl/con_serial_regs.sv
module con_serial_regs #(
  parameter int ADDR_W = 12,
  parameter logic [7:0] RX_VECTOR = 8'hF8,
  parameter logic [7:0] TX_VECTOR = 8'hFC,
  parameter logic [31:0] ID_VALUE = 32'd128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq_req,
  output logic [7:0]        irq_vector,
  output logic              sys_pending
);
  localparam logic [ADDR_W-1:0] OFS_RXS = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] OFS_RXD = ADDR_W'('h84);
  localparam logic [ADDR_W-1:0] OFS_TXS = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] OFS_TXD = ADDR_W'('h8C);
  localparam logic [ADDR_W-1:0] OFS_ID  = ADDR_W'('h100);
  localparam int IE = 6;

  logic [6:0]  rx_ctl, tx_ctl;
  logic        irq_q;
  logic [7:0]  vec_q;
  logic [31:0] rd_mux;

  wire hit_rxs = bus_addr == OFS_RXS;
  wire hit_rxd = bus_addr == OFS_RXD;
  wire hit_txs = bus_addr == OFS_TXS;
  wire hit_txd = bus_addr == OFS_TXD;
  wire hit_id  = bus_addr == OFS_ID;

  wire ack     = bus_wr & (hit_rxs | hit_txs);
  wire rx_fire = rx_ctl[IE] & rx_valid;
  wire tx_fire = tx_ctl[IE];
  wire unused_wdata = ^bus_wdata[31:8];

  assign rx_ready    = bus_rd & hit_rxd & rx_valid;
  assign irq_req     = irq_q;
  assign sys_pending = irq_q;
  assign irq_vector  = vec_q;

  always_comb begin
    rd_mux = '0;
    if (hit_rxs)      rd_mux = {24'd0, rx_valid, rx_ctl};
    else if (hit_rxd) rd_mux = rx_valid ? {24'd0, rx_data} : 32'd0;
    else if (hit_txs) rd_mux = {24'd0, 1'b1, tx_ctl};
    else if (hit_id)  rd_mux = ID_VALUE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ctl    <= '0;
      tx_ctl    <= '0;
      irq_q     <= 1'b0;
      vec_q     <= '0;
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_wr && hit_rxs) rx_ctl <= bus_wdata[6:0];
      if (bus_wr && hit_txs) tx_ctl <= bus_wdata[6:0];

      if (ack)                    irq_q <= 1'b0;
      else if (rx_fire | tx_fire) irq_q <= 1'b1;

      if (tx_fire)      vec_q <= TX_VECTOR;
      else if (rx_fire) vec_q <= RX_VECTOR;

      if (bus_rd) bus_rdata <= rd_mux;

      tx_valid <= bus_wr & hit_txd;
      if (bus_wr && hit_txd) tx_data <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/con_serial_regs_chk.sv
module con_serial_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              irq_req,
  input logic [7:0]        irq_vector,
  input logic              rx_ie,
  input logic              tx_ie
);
  localparam logic [ADDR_W-1:0] A_RXS = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] A_TXS = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] A_TXD = ADDR_W'('h8C);

  wire ack = bus_wr && (bus_addr == A_RXS || bus_addr == A_TXS);

  AST_TX_READY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_TXS |=> bus_rdata[7]); // R3
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_req); // R7
  AST_TX_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ie && !ack |=> irq_req && irq_vector == 8'hFC); // R8
  AST_RX_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ie && rx_valid && !tx_ie && !ack |=> irq_req && irq_vector == 8'hF8); // R5
  AST_CONSUME_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid); // R4
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_TXD |=> tx_valid && tx_data == $past(bus_wdata[7:0])); // R9
  AST_NO_STRAY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_TXD) |=> !tx_valid); // R9
endmodule

bind con_serial_regs con_serial_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .irq_req(irq_req), .irq_vector(irq_vector),
  .rx_ie(rx_ctl[6]), .tx_ie(tx_ctl[6])
);

// File: tb/tb_con_serial_regs.sv
module tb_con_serial_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, irq_req, sys_pending;
  logic [7:0] tx_data, irq_vector;

  con_serial_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_req(irq_req),
    .irq_vector(irq_vector), .sys_pending(sys_pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  byte unsigned rxq[$];

  int m_rxctl, m_txctl, m_irq, m_vec, m_rdata, m_txv, m_txd;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int a;
    bit rv, rxf, txf, ack;
    cycles++;
    a = int'(bus_addr);
    rv = rx_valid;
    if (!rst_n) begin
      m_rxctl = 0; m_txctl = 0; m_irq = 0; m_vec = 0;
      m_rdata = 0; m_txv = 0; m_txd = 0;
    end else begin
      rxf = ((m_rxctl >> 6) & 1) != 0 && rv;
      txf = ((m_txctl >> 6) & 1) != 0;
      ack = bus_wr && (a == 'h80 || a == 'h88);
      if (bus_rd) begin
        case (a)
          'h80: m_rdata = (rv ? 128 : 0) + m_rxctl;
          'h84: m_rdata = rv ? int'(rx_data) : 0;
          'h88: m_rdata = 128 + m_txctl;
          'h100: m_rdata = 128;
          default: m_rdata = 0;
        endcase
      end
      if (ack) m_irq = 0; else if (rxf || txf) m_irq = 1;
      if (txf) m_vec = 'hFC; else if (rxf) m_vec = 'hF8;
      if (bus_wr && a == 'h80) m_rxctl = int'(bus_wdata[6:0]);
      if (bus_wr && a == 'h88) m_txctl = int'(bus_wdata[6:0]);
      m_txv = (bus_wr && a == 'h8C) ? 1 : 0;
      if (bus_wr && a == 'h8C) m_txd = int'(bus_wdata[7:0]);
      if (bus_rd && a == 'h84 && rv) void'(rxq.pop_front());
    end
    rx_valid <= rxq.size() != 0;
    rx_data  <= rxq.size() != 0 ? rxq[0] : 8'h00;
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      vectors++;
      chk("R1/R2/R4/R10", "bus_rdata", bus_rdata, m_rdata);
      chk("R5/R7", "irq_req", irq_req, m_irq);
      chk("R5/R7", "sys_pending", sys_pending, m_irq);
      chk("R6/R8", "irq_vector", irq_vector, m_vec);
      chk("R9", "tx_valid", tx_valid, m_txv);
      if (m_txv) chk("R9", "tx_data", tx_data, m_txd);
      chk("R4", "rx_ready", rx_ready,
          (bus_rd && int'(bus_addr) == 'h84 && rx_valid) ? 1 : 0);
    end
  end

  task automatic op(input bit r, input bit w, input int a, input int d);
    @(negedge clk);
    bus_rd = r; bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    vectors++;
    chk("R11", "reset irq_req", irq_req, 0);
    chk("R11", "reset rdata", bus_rdata, 0);
    chk("R11", "reset tx_valid", tx_valid, 0);
    chk("R11", "reset vector", irq_vector, 0);
    // R1 R2 R3 R10: plain reads of every register
    op(1, 0, 'h80, 0); op(1, 0, 'h88, 0); op(1, 0, 'h100, 0);
    op(1, 0, 'h84, 0); op(1, 0, 'h104, 0); op(1, 0, 'h8C, 0);
    // R5: enable without a byte, then with one
    op(0, 1, 'h80, 'h45); idle(3);
    rxq.push_back(8'h5A); idle(3);
    op(1, 0, 'h80, 0); idle(1);
    // R7: acknowledge while the condition holds, then rearm
    op(0, 1, 'h80, 'h40); idle(2);
    // R4: consume and read empty
    op(1, 0, 'h84, 0); op(1, 0, 'h84, 0); op(1, 0, 'h80, 0);
    op(0, 1, 'h80, 0); idle(2);
    // R6: transmit enable alone
    op(0, 1, 'h88, 'h7F); idle(2); op(1, 0, 'h88, 0);
    // R8: both conditions
    op(0, 1, 'h80, 'h40); rxq.push_back(8'hC3); rxq.push_back(8'h11); idle(3);
    op(1, 0, 'h84, 0); op(1, 0, 'h84, 0); op(1, 0, 'h84, 0);
    op(0, 1, 'h88, 0); op(0, 1, 'h80, 0); idle(2);
    // R9: transmit writes, back to back and spaced
    op(0, 1, 'h8C, 'h1234_56A5); op(0, 1, 'h8C, 'hFF);
    @(negedge clk); bus_wr = 1; bus_addr = AW'('h8C); bus_wdata = 'h33;
    @(negedge clk); bus_wdata = 'h44;
    @(negedge clk); bus_wr = 0; idle(2);
    // R10: unmapped writes change nothing
    op(0, 1, 'h90, 'hFF); op(0, 1, 'h100, 'hFF); op(0, 1, 'h84, 'h7F);
    idle(2); op(1, 0, 'h80, 0); op(1, 0, 'h88, 0); op(1, 0, 'h100, 0);
    idle(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog expired expected end of stimulus");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule